// File: doc/BRIEF.md
# Variable-Frequency Square and Tick Generator

This block is a numerically controlled oscillator in the reference-clock domain. A 16-bit frequency word is loaded as two bytes: a high-byte write is held in a staging register, and the following low-byte write commits both bytes as one word. The word is read as a signed value. Its magnitude, W, is added to a phase accumulator on every clock edge while the start input is high. The output frequency is therefore W / 2^16 of the reference clock.

The block has two outputs. The square output is the most significant bit of the accumulator. The tick output is high for exactly one clock cycle each time the square output rises; a downstream pulse-width stage can use it as a clock enable. Any word whose magnitude is a power of two gives a square wave with exactly 50% duty. For use as a clock enable, the useful magnitudes run from 1 to 32768. While start is low, the accumulator is held at zero and both outputs are low.

Top module: `nco_square_gen`

## Requirements
- R1: After reset, tick and square_out are low and the committed word is zero.
- R2: A write on wr_hi only stages wr_data as the high byte, and the committed word does not change. A write on wr_lo commits {staged high byte, wr_data} at that clock edge, and that word is used from the next edge on.
- R3: The increment W is the committed word when bit 15 of the word is 0. When bit 15 is 1, W is 65536 minus the word (for example, 0xC000 gives 0x4000 and 0xFFFF gives 1). W never exceeds 32768.
- R4: While start is high, the accumulator gains W on each clock edge, starting from zero, and square_out is its bit 15. After the first n edges with start high, the number of cycles with tick high is floor((n*W + 32768) / 65536), and the number of cycles with square_out high is the count of values k*W mod 65536 that are at least 32768, for k = 1..n.
- R5: tick is high in a cycle exactly when square_out rose at that edge, and it is never high in two consecutive cycles.
- R6: When W is a power of two, square_out is high for exactly half of every whole period of 65536/W cycles.
- R7: At the first clock edge that samples start low, the accumulator clears. From then on, square_out and tick stay low until start is high again, whatever word is committed.
- R8: With W equal to zero, tick never pulses and square_out stays low.
- R9: The word 0x8000 gives W = 32768, so square_out toggles on every edge and tick pulses every second cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run enable; when low, the accumulator is held at zero |
| wr_hi | input | 1 | Stage wr_data as the high byte of the word |
| wr_lo | input | 1 | Commit {staged high byte, wr_data} as the word |
| wr_data | input | 8 | Byte write data |
| tick | output | 1 | One-cycle pulse on each rising edge of square_out |
| square_out | output | 1 | Accumulator most significant bit |

## Verification
A committed word takes effect at the edge after the low-byte write. The accumulator holds W one edge after start is first sampled high. square_out and tick are registered-path outputs, valid in the same cycle as the accumulator value they come from. The bench drives inputs on the falling edge and samples after each rising edge, also on the falling edge. Each counted window therefore holds exactly n accumulator values, k*W for k = 1..n, and the expected tick and high counts come straight from the closed-form expressions in R4. The stop check is sampled one edge after start goes low, which is when R7 says the outputs must already be low.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // Interpretation of the committed frequency word
  typedef enum logic {
    WORD_UNSIGNED = 1'b0,
    WORD_SIGNED   = 1'b1
  } word_mode_e;

  localparam int unsigned NCO_BYTE_W_DEF = 8;
endpackage

// File: rtl/nco_word_regs.sv
// Two-byte word loader: the high byte is staged; the low-byte write commits the pair.
module nco_word_regs #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [WORD_W-1:0] word_o
);
  logic [BYTE_W-1:0] hi_stage_q;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_stage_q <= '0;
    end else if (wr_hi) begin
      hi_stage_q <= wr_data;
    end
  end

  // The commit uses the high byte staged before this edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (wr_lo) begin
      word_q <= {hi_stage_q, wr_data};
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/nco_incr_map.sv
// Maps the committed word to the accumulator increment.
module nco_incr_map #(
  parameter int unsigned WORD_W = 16,
  parameter nco_pkg::word_mode_e WORD_MODE = nco_pkg::WORD_SIGNED
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] incr_o
);
  // Magnitude of a two's complement word, kept in the same width
  function automatic logic [WORD_W-1:0] twos_magnitude(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] neg;
    neg = (~w) + WORD_W'(1);
    return w[WORD_W-1] ? neg : w;
  endfunction

  generate
    if (WORD_MODE == nco_pkg::WORD_SIGNED) begin : g_signed
      assign incr_o = twos_magnitude(word_i);
    end else begin : g_unsigned
      assign incr_o = word_i;
    end
  endgenerate
endmodule

// File: rtl/nco_phase_acc.sv
// Phase accumulator: cleared when not running, otherwise adds incr each edge.
module nco_phase_acc #(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [ACC_W-1:0] incr_i,
  output logic             msb_o
);
  logic [ACC_W-1:0] acc_q;

  function automatic logic [ACC_W-1:0] phase_step(input logic [ACC_W-1:0] a,
                                                  input logic [ACC_W-1:0] d);
    return a + d; // wraps modulo 2^ACC_W
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      acc_q <= '0;
    end else begin
      acc_q <= phase_step(acc_q, incr_i);
    end
  end

  assign msb_o = acc_q[ACC_W-1];
endmodule

// File: rtl/nco_rise_tick.sv
// One-cycle pulse on each rising edge of a registered level.
module nco_rise_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic tick_o
);
  logic level_d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_d_q <= 1'b0;
    end else begin
      level_d_q <= level_i;
    end
  end

  assign tick_o = level_i & ~level_d_q;
endmodule

// File: rtl/nco_square_gen.sv
// Variable-frequency square and tick generator (top).
module nco_square_gen #(
  parameter int unsigned BYTE_W = nco_pkg::NCO_BYTE_W_DEF,
  parameter nco_pkg::word_mode_e WORD_MODE = nco_pkg::WORD_SIGNED,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              tick,
  output logic              square_out
);
  // Internal events, named so the checker can observe them
  logic [WORD_W-1:0] word_w;
  logic [WORD_W-1:0] incr_w;
  logic              phase_msb_w;
  logic              rise_w;

  nco_word_regs #(.BYTE_W(BYTE_W)) u_word (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hi   (wr_hi),
    .wr_lo   (wr_lo),
    .wr_data (wr_data),
    .word_o  (word_w)
  );

  nco_incr_map #(.WORD_W(WORD_W), .WORD_MODE(WORD_MODE)) u_map (
    .word_i (word_w),
    .incr_o (incr_w)
  );

  nco_phase_acc #(.ACC_W(WORD_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (start),
    .incr_i (incr_w),
    .msb_o  (phase_msb_w)
  );

  nco_rise_tick u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (phase_msb_w),
    .tick_o  (rise_w)
  );

  assign square_out = phase_msb_w;
  assign tick       = rise_w;
endmodule

// File: rtl/nco_square_chk.sv
// Property checker attached to the generator top.
module nco_square_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              wr_lo,
  input logic              tick,
  input logic              square_out,
  input logic [WORD_W-1:0] word_w,
  input logic [WORD_W-1:0] incr_w
);
  // R2: without a low-byte write the committed word holds
  assert_word_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo |=> $stable(word_w));

  // R3: the increment magnitude is bounded by half the phase range
  assert_incr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    incr_w <= (WORD_W'(1) << (WORD_W - 1)));

  // R5: tick coincides with a rising edge of the square output
  assert_tick_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick == $rose(square_out));

  // R5: tick never lasts two cycles
  assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R7: stopped means quiet outputs from the next edge
  assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!square_out && !tick));

  // R8: zero increment with low output keeps the output low
  assert_zero_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (incr_w == '0 && !square_out) |=> (!square_out && !tick));
endmodule

bind nco_square_gen nco_square_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .wr_lo      (wr_lo),
  .tick       (tick),
  .square_out (square_out),
  .word_w     (word_w),
  .incr_w     (incr_w)
);

// File: tb/nco_square_gen_bench.sv
`timescale 1ns/1ps
module nco_square_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       wr_hi = 1'b0;
  logic       wr_lo = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tick;
  logic       square_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  nco_square_gen u_nco_square_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wr_data(wr_data), .tick(tick), .square_out(square_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Magnitude written as distance from the nearest multiple of 65536
  function automatic longint bench_mag(input logic [15:0] w);
    longint v = longint'(w);
    return (v >= 32768) ? (65536 - v) : v;
  endfunction

  function automatic longint exp_ticks(input longint n, input longint m);
    return (n * m + 32768) / 65536;
  endfunction

  function automatic longint exp_highs(input longint n, input longint m);
    longint h = 0;
    for (longint k = 1; k <= n; k++) if (((k * m) % 65536) >= 32768) h++;
    return h;
  endfunction

  task automatic write_hi(input logic [7:0] b);
    @(negedge clk); wr_hi = 1'b1; wr_data = b;
    @(negedge clk); wr_hi = 1'b0;
  endtask

  task automatic write_lo(input logic [7:0] b);
    @(negedge clk); wr_lo = 1'b1; wr_data = b;
    @(negedge clk); wr_lo = 1'b0;
  endtask

  task automatic write_word(input logic [15:0] w);
    write_hi(w[15:8]);
    write_lo(w[7:0]);
  endtask

  // Run n edges from a cleared accumulator and count outputs, then stop.
  task automatic run_count(input int n, output longint t, output longint h,
                           output longint dbl);
    bit prev_t = 1'b0;
    t = 0; h = 0; dbl = 0;
    @(negedge clk); start = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (tick) t++;
      if (square_out) h++;
      if (tick && prev_t) dbl++;
      prev_t = tick;
    end
    start = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R7 stop edge square", square_out, 0);
    check("R7 stop edge tick", tick, 0);
  endtask

  task automatic scenario(input string req, input logic [15:0] w, input int n);
    longint t, h, d, m;
    write_word(w);
    m = bench_mag(w);
    run_count(n, t, h, d);
    check({req, " tick count"}, t, exp_ticks(n, m));
    check({req, " high count"}, h, exp_highs(n, m));
    check({req, " R5 no back-to-back tick"}, d, 0);
  endtask

  task automatic test_reset;
    @(negedge clk);
    check("R1 reset square", square_out, 0);
    check("R1 reset tick", tick, 0);
  endtask

  task automatic test_zero_word;
    longint t, h, d;
    write_word(16'h0000);
    run_count(200, t, h, d);
    check("R8 zero word ticks", t, 0);
    check("R8 zero word highs", h, 0);
  endtask

  task automatic test_stopped_quiet;
    longint t = 0, h = 0;
    write_word(16'h8000);
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); @(negedge clk);
      if (tick) t++;
      if (square_out) h++;
    end
    check("R7 stopped ticks", t, 0);
    check("R7 stopped highs", h, 0);
  endtask

  task automatic test_half_write;
    longint t, h, d;
    write_word(16'h4000);
    write_hi(8'h10);           // staged only: W stays 0x4000
    run_count(64, t, h, d);
    check("R2 hi-only write ticks", t, 16);
    check("R2 hi-only write highs", h, 32);
    write_lo(8'h00);           // commits 0x1000
    run_count(64, t, h, d);
    check("R2 commit ticks", t, exp_ticks(64, 4096));
    check("R2 commit highs", h, exp_highs(64, 4096));
  endtask

  task automatic test_half_duty;
    longint t, h, d;
    write_word(16'h0100);
    run_count(1024, t, h, d);     // four whole periods of 256
    check("R6 pow2 0x0100 highs half", h, 512);
    check("R6 pow2 0x0100 ticks", t, 4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    test_reset();
    @(negedge clk); rst_n = 1'b1;
    test_reset();
    scenario("R4 W=0x4000", 16'h4000, 64);
    scenario("R4 W=3000", 16'd3000, 2000);
    test_half_duty();
    scenario("R3 word 0xC000", 16'hC000, 64);
    scenario("R3 word 0xFFFF", 16'hFFFF, 40000);
    scenario("R9 word 0x8000", 16'h8000, 64);
    test_zero_word();
    test_stopped_quiet();
    test_half_write();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule